// File: doc/BRIEF.md
# Inset Overlay Window Generator

This block decides, pixel by pixel, what a display raster shows when up to two reduced-size inset pictures are laid over a live picture. The display timing logic supplies the current pixel column and line number, plus a one-cycle pulse at the start of each field. The block compares them against a movable background rectangle and two inset windows, main and sub. It returns a source code for every pixel, a fast-blanking flag for the analog switch, and the colour/brightness code to use when the background is shown.

Each inset is placed relative to the background origin. Its size is set by its own horizontal and vertical reduction factor, chosen from four values. The background and the insets have separate enables. All settings are sampled into shadow registers only on the field-start pulse, so a write in the middle of a field cannot tear the picture. The output is registered one cycle after the pixel coordinates.

Top module: `pip_overlay_gen`

## Requirements
- R1: While `rst_n` is low and after its release, until the first `field_start`, `src` is 0 (live), `fblank` is 0 and `bg_code` is 0. Both enables read as off.
- R2: With the background enabled, `src` is 1 for every pixel where BASE_H+bg_h ≤ x < BASE_H+bg_h+696 and BASE_V+bg_v ≤ y < BASE_V+bg_v+238. No inset may cover that pixel.
- R3: The background enable and the inset enable act alone. Insets appear when the background is off, and the background appears when insets are off.
- R4: Each inset's top-left corner sits at the background origin plus that channel's 8-bit horizontal and vertical offset, whether or not the background is on.
- R5: Inset width is 672, 336, 224 or 168 pixels for horizontal reduction code 0, 1, 2 or 3 (factor 1 to 4).
- R6: Inset height is 228, 114, 76 or 57 lines for vertical reduction code 0, 1, 2 or 3. It is set apart from the width.
- R7: Source codes are 0 live, 1 background, 2 main inset and 3 sub inset. Where windows overlap, sub beats main, and main beats background.
- R8: `fblank` is 1 exactly when `src` is not 0.
- R9: `bg_code` is {brightness[1:0], colour[2:0]}. Brightness codes 0..3 mean 30, 50, 70 and 100 % IRE, and colour codes select one of eight colours.
- R10: Settings present on a cycle with `field_start` high govern the pixels from the next cycle onward. Changes without `field_start` have no effect. The outputs for the coordinates presented at one clock edge appear after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | display pixel clock |
| rst_n | input | 1 | synchronous reset, active low |
| field_start | input | 1 | one-cycle pulse that loads the shadow settings |
| pix_x | input | PX_W | current pixel column |
| line_y | input | LN_W | current display line |
| cfg_bg_on | input | 1 | background enable |
| cfg_pip_on | input | 1 | inset enable |
| cfg_bg_h | input | POS_W | background horizontal offset |
| cfg_bg_v | input | POS_W | background vertical offset |
| cfg_main_h | input | POS_W | main inset horizontal offset |
| cfg_main_v | input | POS_W | main inset vertical offset |
| cfg_sub_h | input | POS_W | sub inset horizontal offset |
| cfg_sub_v | input | POS_W | sub inset vertical offset |
| cfg_main_hred | input | 2 | main horizontal reduction code |
| cfg_main_vred | input | 2 | main vertical reduction code |
| cfg_sub_hred | input | 2 | sub horizontal reduction code |
| cfg_sub_vred | input | 2 | sub vertical reduction code |
| cfg_bg_col | input | 3 | background colour code |
| cfg_bg_bri | input | 2 | background brightness code |
| src | output | 2 | pixel source code |
| fblank | output | 1 | fast-blanking flag |
| bg_code | output | 5 | background brightness and colour |

## Verification
The assertions assume `pix_x` holds a column in the visible raster and that the shadow settings move only on a `field_start` cycle. They also assume a pixel left of BASE_H can never fall in any window, since every offset is unsigned. The stimulus drives coordinates directly rather than free-running counters. It pulses `field_start` only at the head of each scanned field, and it changes settings between pulses only in the scenario aimed at R10. The rows scanned are picked from the current settings: the line just above, the first line, the last line and the line just below the background and each inset.

// File: rtl/pip_overlay_gen.sv
module pip_overlay_gen #(
  parameter int PX_W      = 10,
  parameter int LN_W      = 9,
  parameter int POS_W     = 8,
  parameter int BG_WIDTH  = 696,
  parameter int BG_HEIGHT = 238,
  parameter int FULL_W    = 672,
  parameter int FULL_H    = 228,
  parameter int BASE_H    = 40,
  parameter int BASE_V    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_start,
  input  logic [PX_W-1:0]  pix_x,
  input  logic [LN_W-1:0]  line_y,
  input  logic             cfg_bg_on,
  input  logic             cfg_pip_on,
  input  logic [POS_W-1:0] cfg_bg_h,
  input  logic [POS_W-1:0] cfg_bg_v,
  input  logic [POS_W-1:0] cfg_main_h,
  input  logic [POS_W-1:0] cfg_main_v,
  input  logic [POS_W-1:0] cfg_sub_h,
  input  logic [POS_W-1:0] cfg_sub_v,
  input  logic [1:0]       cfg_main_hred,
  input  logic [1:0]       cfg_main_vred,
  input  logic [1:0]       cfg_sub_hred,
  input  logic [1:0]       cfg_sub_vred,
  input  logic [2:0]       cfg_bg_col,
  input  logic [1:0]       cfg_bg_bri,
  output logic [1:0]       src,
  output logic             fblank,
  output logic [4:0]       bg_code
);
  localparam int CW = PX_W + 2;
  localparam int LW = LN_W + 2;

  logic             sh_bg_on, sh_pip_on;
  logic [POS_W-1:0] sh_bg_h, sh_bg_v, sh_main_h, sh_main_v, sh_sub_h, sh_sub_v;
  logic [1:0]       sh_main_hred, sh_main_vred, sh_sub_hred, sh_sub_vred;
  logic [2:0]       sh_col;
  logic [1:0]       sh_bri;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {sh_bg_on, sh_pip_on} <= '0;
      {sh_bg_h, sh_bg_v, sh_main_h, sh_main_v, sh_sub_h, sh_sub_v} <= '0;
      {sh_main_hred, sh_main_vred, sh_sub_hred, sh_sub_vred} <= '0;
      {sh_col, sh_bri} <= '0;
    end else if (field_start) begin
      sh_bg_on     <= cfg_bg_on;
      sh_pip_on    <= cfg_pip_on;
      sh_bg_h      <= cfg_bg_h;
      sh_bg_v      <= cfg_bg_v;
      sh_main_h    <= cfg_main_h;
      sh_main_v    <= cfg_main_v;
      sh_sub_h     <= cfg_sub_h;
      sh_sub_v     <= cfg_sub_v;
      sh_main_hred <= cfg_main_hred;
      sh_main_vred <= cfg_main_vred;
      sh_sub_hred  <= cfg_sub_hred;
      sh_sub_vred  <= cfg_sub_vred;
      sh_col       <= cfg_bg_col;
      sh_bri       <= cfg_bg_bri;
    end
  end

  function automatic logic [CW-1:0] red_w(input logic [1:0] c);
    case (c)
      2'd0:    return CW'(FULL_W);
      2'd1:    return CW'(FULL_W / 2);
      2'd2:    return CW'(FULL_W / 3);
      default: return CW'(FULL_W / 4);
    endcase
  endfunction

  function automatic logic [LW-1:0] red_h(input logic [1:0] c);
    case (c)
      2'd0:    return LW'(FULL_H);
      2'd1:    return LW'(FULL_H / 2);
      2'd2:    return LW'(FULL_H / 3);
      default: return LW'(FULL_H / 4);
    endcase
  endfunction

  logic [CW-1:0] x, bx0, mx0, sx0;
  logic [LW-1:0] y, by0, my0, sy0;
  logic          hit_bg, hit_main, hit_sub;

  assign x   = CW'(pix_x);
  assign y   = LW'(line_y);
  assign bx0 = CW'(BASE_H) + CW'(sh_bg_h);
  assign by0 = LW'(BASE_V) + LW'(sh_bg_v);
  assign mx0 = bx0 + CW'(sh_main_h);
  assign my0 = by0 + LW'(sh_main_v);
  assign sx0 = bx0 + CW'(sh_sub_h);
  assign sy0 = by0 + LW'(sh_sub_v);

  assign hit_bg   = sh_bg_on && x >= bx0 && x < bx0 + CW'(BG_WIDTH)
                    && y >= by0 && y < by0 + LW'(BG_HEIGHT);
  assign hit_main = sh_pip_on && x >= mx0 && x < mx0 + red_w(sh_main_hred)
                    && y >= my0 && y < my0 + red_h(sh_main_vred);
  assign hit_sub  = sh_pip_on && x >= sx0 && x < sx0 + red_w(sh_sub_hred)
                    && y >= sy0 && y < sy0 + red_h(sh_sub_vred);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src     <= 2'd0;
      fblank  <= 1'b0;
      bg_code <= 5'd0;
    end else begin
      src     <= hit_sub ? 2'd3 : hit_main ? 2'd2 : hit_bg ? 2'd1 : 2'd0;
      fblank  <= hit_bg | hit_main | hit_sub;
      bg_code <= {sh_bri, sh_col};
    end
  end
endmodule

module pip_overlay_gen_chk #(
  parameter int PX_W   = 10,
  parameter int BASE_H = 40,
  parameter int SH_W   = 63
) (
  input logic            clk,
  input logic            rst_n,
  input logic            field_start,
  input logic [PX_W-1:0] pix_x,
  input logic [1:0]      src,
  input logic            fblank,
  input logic            bg_on_q,
  input logic            pip_on_q,
  input logic [SH_W-1:0] shadow
);
  assert_fblank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src != 2'd0) |-> fblank);
  assert_live_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'd0) |-> !fblank);
  assert_no_inset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pip_on_q |=> (src < 2'd2));
  assert_no_bg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bg_on_q |=> (src != 2'd1));
  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> $stable(shadow));
  assert_left_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pix_x) < BASE_H) |=> (src == 2'd0));
endmodule

bind pip_overlay_gen pip_overlay_gen_chk #(.PX_W(PX_W), .BASE_H(BASE_H), .SH_W(2 + 6*POS_W + 13)) u_chk (
  .clk(clk), .rst_n(rst_n), .field_start(field_start), .pix_x(pix_x),
  .src(src), .fblank(fblank), .bg_on_q(sh_bg_on), .pip_on_q(sh_pip_on),
  .shadow({sh_bg_on, sh_pip_on, sh_bg_h, sh_bg_v, sh_main_h, sh_main_v, sh_sub_h, sh_sub_v,
           sh_main_hred, sh_main_vred, sh_sub_hred, sh_sub_vred, sh_col, sh_bri}));

// File: tb/pip_overlay_gen_tb.sv
module pip_overlay_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_H = 40;
  localparam int BASE_V = 10;
  localparam int LINE_PIX = 864;

  logic clk = 0, rst_n = 0, field_start = 0;
  logic [9:0] pix_x = 0;
  logic [8:0] line_y = 0;
  logic bg_on = 0, pip_on = 0;
  logic [7:0] bg_h = 0, bg_v = 0, m_h = 0, m_v = 0, s_h = 0, s_v = 0;
  logic [1:0] m_hr = 0, m_vr = 0, s_hr = 0, s_vr = 0, bri = 0;
  logic [2:0] col = 0;
  logic [1:0] src;
  logic fblank;
  logic [4:0] bg_code;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  // model shadow
  int q_bg, q_pip, q_bh, q_bv, q_mh, q_mv, q_sh, q_sv, q_mhr, q_mvr, q_shr, q_svr, q_col, q_bri;

  pip_overlay_gen u_dut (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .pix_x(pix_x), .line_y(line_y),
    .cfg_bg_on(bg_on), .cfg_pip_on(pip_on), .cfg_bg_h(bg_h), .cfg_bg_v(bg_v),
    .cfg_main_h(m_h), .cfg_main_v(m_v), .cfg_sub_h(s_h), .cfg_sub_v(s_v),
    .cfg_main_hred(m_hr), .cfg_main_vred(m_vr), .cfg_sub_hred(s_hr), .cfg_sub_vred(s_vr),
    .cfg_bg_col(col), .cfg_bg_bri(bri), .src(src), .fblank(fblank), .bg_code(bg_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      $display("FAIL watchdog: run exceeded cycle limit, actual %0d expected <= 200000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int wid(int c); int t[4] = '{672, 336, 224, 168}; return t[c]; endfunction
  function automatic int hgt(int c); int t[4] = '{228, 114, 76, 57}; return t[c]; endfunction

  function automatic int exp_src(int x, int y);
    int bx = BASE_H + q_bh, by = BASE_V + q_bv;
    int mx = bx + q_mh, my = by + q_mv, sx = bx + q_sh, sy = by + q_sv;
    if (q_pip != 0 && x >= sx && x < sx + wid(q_shr) && y >= sy && y < sy + hgt(q_svr)) return 3;
    if (q_pip != 0 && x >= mx && x < mx + wid(q_mhr) && y >= my && y < my + hgt(q_mvr)) return 2;
    if (q_bg != 0 && x >= bx && x < bx + 696 && y >= by && y < by + 238) return 1;
    return 0;
  endfunction

  task automatic check(string t, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      if (fails < 20)
        $display("FAIL %s %s at x=%0d y=%0d: actual %0d expected %0d", t, what, pix_x, line_y, act, exp);
    end
  endtask

  // one pixel: drive, clock, compare against old model shadow, then load shadow
  task automatic px(int x, int y, bit fs);
    int e;
    pix_x = 10'(x); line_y = 9'(y); field_start = fs;
    @(posedge clk); @(negedge clk);
    e = exp_src(x, y);
    check(tag, int'(src), e, "src");
    check("R8", int'(fblank), (e != 0) ? 1 : 0, "fblank");
    check("R9", int'(bg_code), q_bri * 8 + q_col, "bg_code");
    if (fs) begin
      q_bg = int'(bg_on); q_pip = int'(pip_on); q_bh = int'(bg_h); q_bv = int'(bg_v);
      q_mh = int'(m_h); q_mv = int'(m_v); q_sh = int'(s_h); q_sv = int'(s_v);
      q_mhr = int'(m_hr); q_mvr = int'(m_vr); q_shr = int'(s_hr); q_svr = int'(s_vr);
      q_col = int'(col); q_bri = int'(bri);
    end
  endtask

  task automatic scan_line(int y);
    for (int x = 0; x < LINE_PIX; x++) px(x, y, 0);
  endtask

  task automatic run_field(string t);
    int by, ls[12];
    tag = t;
    px(0, 0, 1);
    by = BASE_V + q_bv;
    ls = '{by - 1, by, by + 237, by + 238,
           by + q_mv, by + q_mv + hgt(q_mvr) - 1, by + q_mv + hgt(q_mvr),
           by + q_sv, by + q_sv + hgt(q_svr) - 1, by + q_sv + hgt(q_svr), by + 100, 0};
    foreach (ls[i]) if (ls[i] >= 0 && ls[i] < 512) scan_line(ls[i]);
  endtask

  initial begin
    q_bg = 0; q_pip = 0; q_bh = 0; q_bv = 0; q_mh = 0; q_mv = 0; q_sh = 0; q_sv = 0;
    q_mhr = 0; q_mvr = 0; q_shr = 0; q_svr = 0; q_col = 0; q_bri = 0;
    bg_on = 1; pip_on = 1; col = 3'd5; bri = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared during reset
    check("R1", int'(src), 0, "src in reset");
    check("R1", int'(fblank), 0, "fblank in reset");
    check("R1", int'(bg_code), 0, "bg_code in reset");
    rst_n = 1;
    // R1: no field_start yet, so enables stay off
    tag = "R1";
    scan_line(BASE_V + 50);

    // R2 / R3: background alone, colour and brightness R9
    bg_on = 1; pip_on = 0; bg_h = 0; bg_v = 0; col = 3'd7; bri = 2'd3;
    run_field("R2");
    // R3 / R4 / R5 / R6: insets without background
    bg_on = 0; pip_on = 1; bg_h = 8'd20; bg_v = 8'd12;
    m_h = 8'd10; m_v = 8'd5; m_hr = 2'd0; m_vr = 2'd0;
    s_h = 8'd255; s_v = 8'd255; s_hr = 2'd3; s_vr = 2'd3; col = 3'd1; bri = 2'd0;
    run_field("R3");
    // R7: overlap priority, R4 offsets from a shifted background
    bg_on = 1; bg_h = 8'd255; bg_v = 8'd255;
    m_h = 8'd0; m_v = 8'd0; m_hr = 2'd1; m_vr = 2'd1;
    s_h = 8'd100; s_v = 8'd50; s_hr = 2'd3; s_vr = 2'd3; col = 3'd2; bri = 2'd1;
    run_field("R7");
    // R5 / R6: remaining factors, independent per axis
    bg_h = 8'd3; bg_v = 8'd7;
    m_h = 8'd0; m_v = 8'd40; m_hr = 2'd2; m_vr = 2'd3;
    s_h = 8'd200; s_v = 8'd0; s_hr = 2'd1; s_vr = 2'd2;
    run_field("R5");
    m_hr = 2'd3; m_vr = 2'd2; s_hr = 2'd2; s_vr = 2'd1; s_h = 8'd1; s_v = 8'd120;
    run_field("R6");
    // R10: settings changed mid-field without field_start have no effect
    tag = "R10";
    bg_on = 0; pip_on = 0; col = 3'd6; bri = 2'd3; m_hr = 2'd0;
    scan_line(BASE_V + 7 + 40);
    scan_line(BASE_V + 7 + 130);
    // R10: they take effect at the next field_start
    run_field("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule